// File: doc/BRIEF.md
# Nibble-Serial 8x8 Unsigned Multiplier

This block forms the 16-bit product of two unsigned 8-bit operands using a single 4x4 unsigned multiplier, which it reuses over four clock steps. On each step a two-bit step counter chooses one pairing of operand nibbles. The 8-bit partial product is weighted by a left shift of 0, 4 or 8 bits. It is then added into a 16-bit accumulator register.

A small control state machine sequences the steps. It has five states: idle, lsb, mid, msb and err. A pulse on `start` clears the accumulator and the step counter. The machine then walks through the four steps and raises `done` for one cycle while `product` holds the finished result. The operands must stay stable from the start pulse until `done`. A protocol slip puts the machine in the err state, and it leaves that state only on a new start. Examples of a slip are holding `start` high past the first cycle, or asserting it during a run.

Top module: `nibble_serial_mult`

## Requirements
- R1: While `rst` is high at a rising edge, the block returns to idle (`state_code` 0), with `done` low and `product` zero.
- R2: `start` high at an edge clears `product` to zero and the step counter to 0. In idle, it moves the block to lsb (`state_code` 1).
- R3: The fourth step is taken in msb with `start` low. On the edge after a start, counting as one the edge that samples `start` in idle, is the fifth edge. From that edge `done` is high for exactly one cycle, `state_code` is 0 and `product` equals op_a*op_b.
- R4: State codes are idle=0, lsb=1, mid=2, msb=3 and err=4. A clean run shows the sequence 1, 2, 2, 3, 0 after the start edge.
- R5: The step counter value picks the nibble pair and the weight. Step 0 adds a[3:0]*b[3:0]. Step 1 adds a[3:0]*b[7:4] shifted left by 4. Step 2 adds a[7:4]*b[3:0] shifted left by 4. Step 3 adds a[7:4]*b[7:4] shifted left by 8. `product` shows each running sum after its step.
- R6: `start` still high in lsb sends the block to err. In err with `start` low, the block stays in err with `product` unchanged and `done` low. `start` high in err moves it to lsb with `product` cleared, and a following clean run gives the correct product.
- R7: `start` high while in mid or msb aborts the run. The block goes to err and `product` is cleared, and `done` stays low.
- R8: In idle with `start` low, `product` holds its last value and `done` stays low after its single cycle.
- R9: Operand corner values 0, 1, 15, 16, 240 and 255 in every combination produce the exact product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a multiply; clears accumulator and step counter |
| op_a | input | 8 | Unsigned multiplicand, stable during a run |
| op_b | input | 8 | Unsigned multiplier, stable during a run |
| product | output | 16 | Accumulator; final product when `done` is high |
| done | output | 1 | One-cycle flag marking the finished product |
| state_code | output | 3 | Current control state code |

## Verification
The err state is the hardest thing to reach and leave, because a normal start pulse never enters it. The bench holds `start` high for a second cycle, which pushes the block from lsb into err. It then drops `start` so the block dwells in err, and checks that nothing moves. After that it pulses `start` again and runs a full multiply out of err. Separate scenarios raise `start` in the middle of mid and of msb, to confirm that an aborted run clears the sum and never raises `done`.

// File: rtl/nsm_pkg.sv
`timescale 1ns/1ps
package nsm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LSB  = 3'd1,
    ST_MID  = 3'd2,
    ST_MSB  = 3'd3,
    ST_ERR  = 3'd4
  } step_state_e;

  // weight codes for the partial-product shifter
  localparam logic [1:0] SH_NONE = 2'b00;
  localparam logic [1:0] SH_ONE  = 2'b01;
  localparam logic [1:0] SH_TWO  = 2'b10;
endpackage

// File: rtl/nsm_nibble_mult.sv
`timescale 1ns/1ps
module nsm_nibble_mult #(
  parameter int NIB = 4
) (
  input  logic [NIB-1:0]   a,
  input  logic [NIB-1:0]   b,
  output logic [2*NIB-1:0] p
);
  localparam int PW = 2 * NIB;

  // shift-and-add array, one row per multiplier bit
  logic [PW-1:0] row [NIB];
  logic [PW-1:0] sum [NIB+1];

  assign sum[0] = '0;
  for (genvar i = 0; i < NIB; i++) begin : g_row
    assign row[i]   = b[i] ? (PW'(a) << i) : '0;
    assign sum[i+1] = sum[i] + row[i];
  end
  assign p = sum[NIB];
endmodule

// File: rtl/nsm_step_ctrl.sv
`timescale 1ns/1ps
module nsm_step_ctrl
  import nsm_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  output step_state_e state,
  output logic [1:0]  step,
  output logic        step_go,
  output logic        last_go
);
  step_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: nxt = start ? ST_LSB : ST_IDLE;
      ST_LSB:  nxt = (!start && step == 2'd0) ? ST_MID : ST_ERR;
      ST_MID: begin
        if (!start && step == 2'd1)      nxt = ST_MID;
        else if (!start && step == 2'd2) nxt = ST_MSB;
        else                             nxt = ST_ERR;
      end
      ST_MSB:  nxt = (!start && step == 2'd3) ? ST_IDLE : ST_ERR;
      ST_ERR:  nxt = start ? ST_LSB : ST_ERR;
      default: nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    step_go = 1'b0;
    if (!start) begin
      unique case (state)
        ST_LSB:  step_go = (step == 2'd0);
        ST_MID:  step_go = (step == 2'd1) || (step == 2'd2);
        ST_MSB:  step_go = (step == 2'd3);
        default: step_go = 1'b0;
      endcase
    end
  end

  assign last_go = (state == ST_MSB) && !start && (step == 2'd3);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      step  <= '0;
    end else begin
      state <= nxt;
      step  <= start ? 2'd0 : step + 2'd1;
    end
  end
endmodule

// File: rtl/nsm_datapath.sv
`timescale 1ns/1ps
module nsm_datapath
  import nsm_pkg::*;
#(
  parameter int NIB = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [2*NIB-1:0] op_a,
  input  logic [2*NIB-1:0] op_b,
  input  logic [1:0]     step,
  input  logic           step_go,
  input  logic           acc_clr,
  output logic [4*NIB-1:0] acc
);
  localparam int PPW = 2 * NIB;
  localparam int AW  = 4 * NIB;

  logic [NIB-1:0] nib_a, nib_b;
  logic [PPW-1:0] pp;
  logic [1:0]     sh_code;
  logic [AW-1:0]  pp_wide, pp_shift;

  // step bit 1 picks the high nibble of a, bit 0 the high nibble of b
  assign nib_a = step[1] ? op_a[2*NIB-1:NIB] : op_a[NIB-1:0];
  assign nib_b = step[0] ? op_b[2*NIB-1:NIB] : op_b[NIB-1:0];

  nsm_nibble_mult #(.NIB(NIB)) u_mul (
    .a(nib_a),
    .b(nib_b),
    .p(pp)
  );

  always_comb begin
    unique case (step)
      2'd0:    sh_code = SH_NONE;
      2'd3:    sh_code = SH_TWO;
      default: sh_code = SH_ONE;
    endcase
  end

  assign pp_wide = AW'(pp);

  always_comb begin
    unique case (sh_code)
      SH_ONE:  pp_shift = pp_wide << NIB;
      SH_TWO:  pp_shift = pp_wide << (2 * NIB);
      default: pp_shift = pp_wide;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || acc_clr) acc <= '0;
    else if (step_go)   acc <= acc + pp_shift;
  end
endmodule

// File: rtl/nibble_serial_mult.sv
`timescale 1ns/1ps
module nibble_serial_mult
  import nsm_pkg::*;
#(
  parameter int NIB = 4,
  localparam int OW = 2 * NIB,
  localparam int PROD_W = 4 * NIB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [OW-1:0]     op_a,
  input  logic [OW-1:0]     op_b,
  output logic [PROD_W-1:0] product,
  output logic              done,
  output logic [2:0]        state_code
);
  step_state_e state;
  logic [1:0]  step;
  logic        step_go, last_go;

  nsm_step_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .state  (state),
    .step   (step),
    .step_go(step_go),
    .last_go(last_go)
  );

  nsm_datapath #(.NIB(NIB)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .op_a   (op_a),
    .op_b   (op_b),
    .step   (step),
    .step_go(step_go),
    .acc_clr(start),
    .acc    (product)
  );

  always_ff @(posedge clk) begin
    if (rst) done <= 1'b0;
    else     done <= last_go;
  end

  assign state_code = state;
endmodule

// File: rtl/nsm_checker.sv
`timescale 1ns/1ps
module nsm_checker #(
  parameter int PW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [PW-1:0] product,
  input logic          done,
  input logic [2:0]    state_code
);
  a_r2_idle_start: assert property (@(posedge clk) disable iff (rst)
    (state_code == 3'd0 && start) |=> state_code == 3'd1);

  a_r2_start_clears: assert property (@(posedge clk) disable iff (rst)
    start |=> product == '0);

  a_r3_done_after_msb: assert property (@(posedge clk) disable iff (rst)
    (state_code == 3'd3 && !start) |=> (done && state_code == 3'd0));

  a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r4_legal_code: assert property (@(posedge clk) disable iff (rst)
    state_code <= 3'd4);

  a_r6_err_dwell: assert property (@(posedge clk) disable iff (rst)
    (state_code == 3'd4 && !start) |=> (state_code == 3'd4 && $stable(product) && !done));

  a_r7_abort_run: assert property (@(posedge clk) disable iff (rst)
    (start && (state_code == 3'd2 || state_code == 3'd3)) |=> (state_code == 3'd4 && !done));

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (state_code == 3'd0 && !start) |=> $stable(product));
endmodule

bind nibble_serial_mult nsm_checker #(.PW(PROD_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .product   (product),
  .done      (done),
  .state_code(state_code)
);

// File: tb/nibble_serial_mult_bench.sv
`timescale 1ns/1ps
module nibble_serial_mult_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  op_a = '0, op_b = '0;
  logic [15:0] product;
  logic        done;
  logic [2:0]  state_code;
  int checks = 0;
  int errors = 0;
  int lcg = 12345;

  always #10 clk = ~clk;

  nibble_serial_mult u_nibble_serial_mult (
    .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
    .product(product), .done(done), .state_code(state_code)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic t_reset();
    rst = 1'b1; start = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 state", state_code, 0);
    chk("R1 done", done, 0);
    chk("R1 product", product, 0);
    rst = 1'b0;
  endtask

  // full run with per-step checks; begins at a negedge
  task automatic t_detail(input int a, input int b);
    int s0, s1, s2, s3;
    s0 = (a % 16) * (b % 16);
    s1 = s0 + (((a % 16) * (b / 16)) << 4);
    s2 = s1 + (((a / 16) * (b % 16)) << 4);
    s3 = s2 + (((a / 16) * (b / 16)) << 8);
    op_a = 8'(a); op_b = 8'(b); start = 1'b1;
    @(negedge clk);
    chk("R2 lsb", state_code, 1);
    chk("R2 cleared", product, 0);
    start = 1'b0;
    @(negedge clk);
    chk("R4 mid", state_code, 2); chk("R5 step0", product, s0);
    @(negedge clk);
    chk("R4 mid2", state_code, 2); chk("R5 step1", product, s1);
    @(negedge clk);
    chk("R4 msb", state_code, 3); chk("R5 step2", product, s2);
    chk("R3 no early done", done, 0);
    @(negedge clk);
    chk("R4 idle", state_code, 0); chk("R3 done", done, 1);
    chk("R3 product", product, a * b);
    @(negedge clk);
    chk("R3 done drops", done, 0); chk("R8 holds", product, a * b);
  endtask

  task automatic t_quick(input string req, input int a, input int b);
    op_a = 8'(a); op_b = 8'(b); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    chk(req, {done, product}, {1'b1, 16'(a * b)});
  endtask

  task automatic t_err_lsb();
    op_a = 8'd200; op_b = 8'd77; start = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R6 err from lsb", state_code, 4);
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk("R6 err dwell", state_code, 4);
    chk("R6 err done low", done, 0);
    chk("R6 err product", product, 0);
    start = 1'b1;
    @(negedge clk);
    chk("R6 err to lsb", state_code, 1);
    start = 1'b0;
    repeat (4) @(negedge clk);
    chk("R6 recovered", {done, product}, {1'b1, 16'(200 * 77)});
  endtask

  task automatic t_abort(input int steps, input int exp_state);
    op_a = 8'd255; op_b = 8'd255; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (steps) @(negedge clk);
    chk("R7 pre-abort state", state_code, exp_state);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R7 abort err", state_code, 4);
    chk("R7 abort cleared", product, 0);
    repeat (3) @(negedge clk);
    chk("R7 no done", done, 0);
  endtask

  task automatic t_idle_hold();
    t_quick("R8 setup", 123, 45);
    repeat (6) @(negedge clk);
    chk("R8 idle product", product, 123 * 45);
    chk("R8 idle done", done, 0);
    chk("R8 idle state", state_code, 0);
  endtask

  task automatic t_corners();
    int vals[6] = '{0, 1, 15, 16, 240, 255};
    foreach (vals[i]) foreach (vals[j]) t_quick("R9 corner", vals[i], vals[j]);
  endtask

  task automatic t_random(input int n);
    for (int k = 0; k < n; k++) begin
      int a, b;
      lcg = lcg * 1103515245 + 12345;
      a = (lcg >>> 8) & 255;
      b = (lcg >>> 16) & 255;
      t_quick("R3 random", a, b);
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_detail(8'hA7, 8'h3C);
    t_detail(255, 255);
    t_detail(16, 1);
    t_err_lsb();
    t_abort(1, 2);
    t_abort(3, 3);
    t_idle_hold();
    t_corners();
    t_random(2000);
    finish_run();
  end

  initial begin
    #(20 * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end
endmodule